// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block tracks which column each data beat of a single-data-rate SDRAM burst addresses. A controller or a memory model uses it to predict the column for every beat. It takes a three-bit burst-length code, a wrap-order select, a start column with a start pulse, a stop pulse and a clock enable. It reports the column of the current beat, a flag that marks a valid beat, and a flag that marks the final beat of a burst that ran to completion.

A start pulse loads the column and the burst configuration. The first beat appears in the next cycle, and one beat follows on every enabled cycle after that. A fixed-length burst keeps its upper column bits and turns over only the low bits inside its aligned block. A full-page burst runs across all columns and wraps at the top. It keeps going until a stop or a new start arrives. While clock enable is low, everything holds.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `beat_valid` and `burst_done` are 0 and `col` is 0.
- R2: The `bl_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats, code 7 gives a full-page burst, and codes 4, 5 and 6 give a single beat. Beats come one per enabled cycle, and the first beat shows on `beat_valid` in the cycle after the start.
- R3: With `interleave`=0, beat i of a fixed burst of length L has low log2(L) column bits equal to (start_col mod L + i) mod L. The remaining upper bits stay equal to those of start_col.
- R4: With `interleave`=1, beat i of a fixed burst of length L has low log2(L) bits equal to (start_col mod L) XOR i. The upper bits stay unchanged.
- R5: `burst_done` is 1 only together with the last beat of a fixed-length burst. In the next enabled cycle `beat_valid` drops to 0, unless a new start arrives.
- R6: A full-page burst addresses (start_col + i) mod 512 whatever the value of `interleave`. It never raises `burst_done` and continues past 512 beats.
- R7: A stop while a burst is running, with cke high and no start, makes `beat_valid` 0 from the next cycle, with no `burst_done`. A stop while idle has no effect.
- R8: A start during a burst restarts the sequence at the new column with the new configuration. A start together with a stop counts as a start.
- R9: While cke is low, `col`, `beat_valid` and `burst_done` hold their values, and start and stop are ignored.
- R10: `bl_code` and `interleave` are taken only at start. Changes to them during a burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the sequencer |
| bl_code | input | 3 | Burst-length code (see R2) |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects wrapping increment |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | End the running burst |
| col | output | 9 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented in this cycle |
| burst_done | output | 1 | This beat ends a fixed-length burst |

## Verification
Every start column from 0 to 511 is driven through every burst code in both wrap orders. This separates increment wrap from XOR wrap, and it shows whether upper bits leak when the block boundary is crossed at each length. The reserved codes are covered by the same sweep. Full-page bursts are run past the 512-column wrap with the interleave select set, which shows that the select is ignored. Directed sequences then stop a burst partway, restart it, change the configuration mid-burst and hold clock enable low on middle and final beats. These tell early termination, restart priority, sampling at start and the freeze apart from normal completion.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;
  localparam int BLC_W = 3;

  localparam logic [BLC_W-1:0] BLC_PAGE = 3'd7;

  // log2 of a fixed burst length; reserved codes behave as one beat
  function automatic logic [3:0] blc_log2(input logic [BLC_W-1:0] code);
    case (code)
      3'd1:    return 4'd1;
      3'd2:    return 4'd2;
      3'd3:    return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic blc_is_page(input logic [BLC_W-1:0] code);
    return code == BLC_PAGE;
  endfunction
endpackage

// File: rtl/sbcg_cfg_decode.sv
module sbcg_cfg_decode
  import sbcg_pkg::*;
#(
  parameter int LG_W = 4
) (
  input  logic [BLC_W-1:0] bl_code,
  output logic [LG_W-1:0]  blk_lg,
  output logic             blk_page
);
  always_comb begin
    blk_lg   = LG_W'(blc_log2(bl_code));
    blk_page = blc_is_page(bl_code);
  end
endmodule

// File: rtl/sbcg_beat_ctr.sv
module sbcg_beat_ctr #(
  parameter int COL_W = 9,
  parameter int LG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic             stop,
  input  logic [LG_W-1:0]  lg_in,
  input  logic             page_in,
  input  logic             intl_in,
  input  logic [COL_W-1:0] blk_mask,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [LG_W-1:0]  lg_q,
  output logic             page_q,
  output logic             intl_q,
  output logic             last_beat
);
  assign last_beat = active && !page_q && (beat == blk_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      lg_q   <= '0;
      page_q <= 1'b0;
      intl_q <= 1'b0;
    end else if (cke) begin
      if (start) begin
        active <= 1'b1;
        beat   <= '0;
        lg_q   <= lg_in;
        page_q <= page_in;
        intl_q <= intl_in;
      end else if (stop) begin
        active <= 1'b0;
      end else if (active) begin
        if (last_beat) active <= 1'b0;
        else           beat   <= beat + 1'b1;
      end
    end
  end

  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !page_q) |-> ((beat & ~blk_mask) == '0));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && stop && !start) |=> !active);
endmodule

// File: rtl/sbcg_col_map.sv
module sbcg_col_map #(
  parameter int COL_W = 9,
  parameter int LG_W  = 4
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [LG_W-1:0]  lg,
  input  logic             page,
  input  logic             intl,
  output logic [COL_W-1:0] blk_mask,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] xor_val;
  logic             use_xor;

  assign seq_sum = base + beat;
  assign xor_val = base ^ beat;
  assign use_xor = intl && !page;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign blk_mask[b] = page || (LG_W'(b) < lg);
    assign col[b] = !blk_mask[b] ? base[b] : (use_xor ? xor_val[b] : seq_sum[b]);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sbcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             burst_done
);
  localparam int LG_W = $clog2(COL_W + 1);

  logic [LG_W-1:0]  dec_lg, lg_q;
  logic             dec_page, page_q, intl_q;
  logic             active, last_beat;
  logic [COL_W-1:0] beat, blk_mask, base_q;

  sbcg_cfg_decode #(.LG_W(LG_W)) u_dec (
    .bl_code (bl_code),
    .blk_lg  (dec_lg),
    .blk_page(dec_page)
  );

  sbcg_beat_ctr #(.COL_W(COL_W), .LG_W(LG_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .start    (start),
    .stop     (stop),
    .lg_in    (dec_lg),
    .page_in  (dec_page),
    .intl_in  (interleave),
    .blk_mask (blk_mask),
    .active   (active),
    .beat     (beat),
    .lg_q     (lg_q),
    .page_q   (page_q),
    .intl_q   (intl_q),
    .last_beat(last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            base_q <= '0;
    else if (cke && start) base_q <= start_col;
  end

  sbcg_col_map #(.COL_W(COL_W), .LG_W(LG_W)) u_map (
    .base    (base_q),
    .beat    (beat),
    .lg      (lg_q),
    .page    (page_q),
    .intl    (intl_q),
    .blk_mask(blk_mask),
    .col     (col)
  );

  assign beat_valid = active;
  assign burst_done = last_beat;

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && start) |=> (beat_valid && col == $past(start_col)));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && cke && !start) |=> !beat_valid);

  p_done_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid);

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cke && rst_n) |-> ($stable(col) && $stable(beat_valid) && $stable(burst_done)));
endmodule

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic [2:0] bl_code = '0;
  logic       interleave = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       stop = 1'b0;
  logic [8:0] col;
  logic       beat_valid;
  logic       burst_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .cke(cke), .bl_code(bl_code),
    .interleave(interleave), .start(start), .start_col(start_col),
    .stop(stop), .col(col), .beat_valid(beat_valid), .burst_done(burst_done)
  );

  function automatic int exp_len(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int code, bit il, int i);
    int len = exp_len(code);
    int lo, hi;
    if (code == 7) return (s + i) % 512;
    lo = s % len;
    hi = s - lo;
    if (il) return hi + (lo ^ i);
    return hi + ((lo + i) % len);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int ecol, bit ev, bit ed);
    n_run++;
    if (beat_valid !== ev || burst_done !== ed || (ev && col !== 9'(ecol))) begin
      n_fail++;
      $display("FAIL %s: col=%0d valid=%0b done=%0b expected col=%0d valid=%0b done=%0b",
               req, col, beat_valid, burst_done, ecol, ev, ed);
    end
  endtask

  task automatic run_burst(int code, bit il, int s, string req);
    int len = exp_len(code);
    bl_code = 3'(code); interleave = il; start_col = 9'(s); start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk(req, exp_col(s, code, il, i), 1'b1, i == len - 1);
      tick();
    end
    chk(req, 0, 1'b0, 1'b0); // R5: idle after last beat
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    n_run++;
    if (col !== 9'd0 || beat_valid !== 1'b0 || burst_done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: col=%0d valid=%0b done=%0b expected 0 0 0", col, beat_valid, burst_done);
    end
    rst_n = 1'b1;
    tick();
    chk("R1", 0, 1'b0, 1'b0);

    // R2/R3/R4: sweep every fixed code, both orders, all start columns
    for (int code = 0; code < 7; code++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 512; s++)
          run_burst(code, il[0], s, il ? "R4" : "R3");

    // R6: full page past the wrap, interleave ignored
    for (int k = 0; k < 3; k++) begin
      int s = (k == 0) ? 500 : (k == 1 ? 0 : 257);
      bl_code = 3'd7; interleave = k[0] ? 1'b0 : 1'b1; start_col = 9'(s); start = 1'b1;
      tick();
      start = 1'b0;
      for (int i = 0; i < 530; i++) begin
        chk("R6", (s + i) % 512, 1'b1, 1'b0);
        tick();
      end
      stop = 1'b1;
      tick();
      stop = 1'b0;
      chk("R7", 0, 1'b0, 1'b0);
    end

    // R7: stop mid fixed burst
    bl_code = 3'd3; interleave = 1'b0; start_col = 9'd42; start = 1'b1;
    tick(); start = 1'b0;
    for (int i = 0; i < 3; i++) begin chk("R7", exp_col(42, 3, 0, i), 1'b1, 1'b0); tick(); end
    chk("R7", exp_col(42, 3, 0, 3), 1'b1, 1'b0);
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R7", 0, 1'b0, 1'b0);
    tick();
    chk("R7", 0, 1'b0, 1'b0);
    // R7: stop while idle has no effect on the next burst
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R7", 0, 1'b0, 1'b0);
    run_burst(2, 1'b1, 13, "R7");

    // R8: restart mid burst with new configuration
    bl_code = 3'd3; interleave = 1'b0; start_col = 9'd8; start = 1'b1;
    tick(); start = 1'b0;
    chk("R8", 8, 1'b1, 1'b0); tick();
    chk("R8", 9, 1'b1, 1'b0);
    run_burst(2, 1'b1, 102, "R8");
    // R8: start with stop in the same cycle counts as start
    bl_code = 3'd1; interleave = 1'b0; start_col = 9'd77; start = 1'b1; stop = 1'b1;
    tick(); start = 1'b0; stop = 1'b0;
    chk("R8", 77, 1'b1, 1'b0); tick();
    chk("R8", 76, 1'b1, 1'b1); tick();
    chk("R8", 0, 1'b0, 1'b0);

    // R10: configuration changes after start are ignored
    bl_code = 3'd3; interleave = 1'b0; start_col = 9'd13; start = 1'b1;
    tick(); start = 1'b0; bl_code = 3'd0; interleave = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R10", exp_col(13, 3, 0, i), 1'b1, i == 7);
      tick();
    end
    chk("R10", 0, 1'b0, 1'b0);

    // R9: freeze mid burst, start/stop ignored while held
    bl_code = 3'd3; interleave = 1'b1; start_col = 9'd21; start = 1'b1;
    tick(); start = 1'b0;
    chk("R9", exp_col(21, 3, 1, 0), 1'b1, 1'b0); tick();
    chk("R9", exp_col(21, 3, 1, 1), 1'b1, 1'b0);
    cke = 1'b0; start = 1'b1; stop = 1'b1; start_col = 9'd300;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9", exp_col(21, 3, 1, 1), 1'b1, 1'b0);
    end
    cke = 1'b1; start = 1'b0; stop = 1'b0;
    for (int i = 2; i < 8; i++) begin
      tick();
      chk("R9", exp_col(21, 3, 1, i), 1'b1, i == 7);
    end
    // R9: freeze on final beat holds burst_done
    cke = 1'b0;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R9", exp_col(21, 3, 1, 7), 1'b1, 1'b1);
    end
    cke = 1'b1;
    tick();
    chk("R9", 0, 1'b0, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule